// File: doc/BRIEF.md
# Byte-Layer Idle/Escape Codec

This block sits between a packet framer and a serial word shifter on a link that moves 32-bit words. In the outbound direction it takes a byte stream, turns every byte that collides with one of the two reserved byte-layer codes into a two-byte escape pair, and packs the resulting bytes into words. The first byte goes into the most significant lane. A word is handed to the shifter once all four lanes are filled. While the controller asserts a flush request, the word is also handed over early, with the unfilled lanes padded with idle code. If nothing is buffered, a flush yields a word made only of idle code, which is what the shifter clocks out while it reads a response.

In the inbound direction it takes words from the shifter and splits them into bytes, most significant lane first. It discards idle fill, and it undoes escape pairs, including pairs split across a word boundary. The shifter marks the final word of each read burst. At the end of that burst the block raises a one-cycle done pulse, together with an empty flag when the burst delivered no data byte at all.

Top module: `bytelink_codec`

## Requirements
- R1: After reset, `txw_valid` is 0 while `tx_flush` is low, `tx_ready` is 1, `rxw_ready` is 1, and `rx_valid`, `rx_done` and `rx_empty` are 0.
- R2: Outbound bytes other than 0x4A and 0x4D are carried unchanged and in order, packed big-endian: the first byte of a word occupies bits 31:24 and the fourth occupies bits 7:0.
- R3: An outbound byte equal to 0x4A becomes the pair 0x4D, 0x6A, and a byte equal to 0x4D becomes the pair 0x4D, 0x6D (escape code, then the byte XOR 0x20).
- R4: A word is offered as soon as four bytes are packed, and `tx_ready` stays low until it is taken. With `tx_flush` high, a partly filled word is offered with its unfilled low lanes set to 0x4A.
- R5: With `tx_flush` high and no byte buffered, the offered word is 0x4A4A4A4A.
- R6: An inbound word is delivered as bytes in the order bits 31:24, 23:16, 15:8, 7:0.
- R7: An inbound 0x4A that does not follow an escape code is dropped and never appears on `rx_byte`.
- R8: An inbound 0x4D is dropped, and the byte after it is delivered XOR 0x20, whatever its value (0x6A gives 0x4A, 0x6D gives 0x4D).
- R9: An inbound escape code in lane 7:0 applies to lane 31:24 of the next word.
- R10: One cycle after the last lane of a word received with `rxw_last` high is consumed, `rx_done` pulses for one cycle. `rx_empty` pulses with it exactly when no byte was delivered since the previous burst ended.
- R11: While `rx_valid` is high and `rx_ready` low, `rx_byte` holds its value. While a full word waits with `txw_ready` low, `txw_valid` stays high and `txw_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_byte | input | 8 | Outbound byte from the packet layer |
| tx_valid | input | 1 | Outbound byte valid |
| tx_ready | output | 1 | Outbound byte accepted |
| tx_flush | input | 1 | Offer the current word now, padded with idle code |
| txw_data | output | 32 | Word to the serial shifter, first byte in bits 31:24 |
| txw_valid | output | 1 | Word valid |
| txw_ready | input | 1 | Shifter takes the word |
| rxw_data | input | 32 | Word from the serial shifter |
| rxw_last | input | 1 | Word is the final one of a read burst |
| rxw_valid | input | 1 | Inbound word valid |
| rxw_ready | output | 1 | Inbound word accepted |
| rx_byte | output | 8 | Decoded byte to the packet layer |
| rx_valid | output | 1 | Decoded byte valid |
| rx_ready | input | 1 | Packet layer takes the byte |
| rx_done | output | 1 | One-cycle pulse at the end of a read burst |
| rx_empty | output | 1 | With `rx_done`: the burst carried no data byte |

## Verification
The outbound side is driven with a plain run of four ordinary bytes, which shows the lane order. Each reserved code followed by a flush shows the escape pairs and the idle padding. A flush with nothing queued must give an all-idle word. The inbound side receives an ordinary word, an all-idle burst, a word with idle bytes mixed into the data, an escape pair inside one word, and an escape whose second byte lands in the next word. These cases separate a dropped idle byte from an escaped one, and a burst that carries data from an empty one. Stall tests on both sides hold the ready inputs low and confirm that the offered byte and word do not move.

// File: rtl/bytelink_pkg.sv
package bytelink_pkg;
    localparam logic [7:0] IDLE_CODE = 8'h4A;
    localparam logic [7:0] ESC_CODE  = 8'h4D;
    localparam logic [7:0] FLIP_MASK = 8'h20;

    function automatic logic is_reserved(input logic [7:0] b);
        return (b == IDLE_CODE) || (b == ESC_CODE);
    endfunction
endpackage

// File: rtl/bl_tx_escaper.sv
module bl_tx_escaper
    import bytelink_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_byte,
    input  logic       in_valid,
    output logic       in_ready,
    output logic [7:0] out_byte,
    output logic       out_valid,
    input  logic       out_ready
);
    typedef struct packed {
        logic       pend;
        logic [7:0] held;
    } esc_state_t;

    esc_state_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        out_valid = s_q.pend | in_valid;
        out_byte  = s_q.pend ? s_q.held : (is_reserved(in_byte) ? ESC_CODE : in_byte);
        in_ready  = !s_q.pend && out_ready;
        if (out_valid && out_ready) begin
            if (s_q.pend) begin
                s_d.pend = 1'b0;
            end else if (is_reserved(in_byte)) begin
                s_d.pend = 1'b1;
                s_d.held = in_byte ^ FLIP_MASK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: an escape code taken from a reserved input is followed by the flipped byte
    a_r3_pair_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !s_q.pend && is_reserved(in_byte))
        |=> (out_valid && (out_byte == 8'h6A || out_byte == 8'h6D)));
endmodule

// File: rtl/bl_tx_packer.sv
module bl_tx_packer
    import bytelink_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      in_byte,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            flush,
    output logic [NB*8-1:0] w_data,
    output logic            w_valid,
    input  logic            w_ready
);
    localparam int CW = $clog2(NB + 1);
    localparam logic [CW-1:0] FULL = CW'(NB);

    typedef struct packed {
        logic [NB*8-1:0] lanes;
        logic [CW-1:0]   cnt;
    } pk_state_t;

    pk_state_t s_q, s_d;
    logic fire;

    always_comb begin
        s_d      = s_q;
        w_valid  = (s_q.cnt == FULL) || flush;
        fire     = w_valid && w_ready;
        in_ready = (s_q.cnt < FULL) && !fire;
        for (int i = 0; i < NB; i++) begin
            w_data[(NB-1-i)*8 +: 8] = (i < int'(s_q.cnt)) ? s_q.lanes[(NB-1-i)*8 +: 8] : IDLE_CODE;
        end
        if (fire) begin
            s_d.cnt = '0;
        end else if (in_valid && in_ready) begin
            for (int i = 0; i < NB; i++) begin
                if (i == int'(s_q.cnt)) s_d.lanes[(NB-1-i)*8 +: 8] = in_byte;
            end
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL);

    a_r11_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && !w_ready && s_q.cnt == FULL) |=> (w_valid && $stable(w_data)));
endmodule

// File: rtl/bl_rx_unpacker.sv
module bl_rx_unpacker
    import bytelink_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NB*8-1:0] w_data,
    input  logic            w_last,
    input  logic            w_valid,
    output logic            w_ready,
    output logic [7:0]      o_byte,
    output logic            o_valid,
    input  logic            o_ready,
    output logic            done,
    output logic            empty
);
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IW-1:0] LAST_LANE = IW'(NB - 1);

    typedef struct packed {
        logic [NB*8-1:0] word;
        logic [IW-1:0]   idx;
        logic            have;
        logic            last;
        logic            esc;
        logic            seen;
        logic            done;
        logic            empty;
    } un_state_t;

    un_state_t s_q, s_d;
    logic [7:0] cur;
    logic       adv;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.empty = 1'b0;
        cur       = s_q.word[(NB-1-int'(s_q.idx))*8 +: 8];
        o_valid   = s_q.have && (s_q.esc || !is_reserved(cur));
        o_byte    = s_q.esc ? (cur ^ FLIP_MASK) : cur;
        adv       = s_q.have && (!o_valid || o_ready);
        w_ready   = !s_q.have;
        if (w_valid && w_ready) begin
            s_d.word = w_data;
            s_d.last = w_last;
            s_d.have = 1'b1;
            s_d.idx  = '0;
        end
        if (adv) begin
            s_d.esc  = !s_q.esc && (cur == ESC_CODE);
            s_d.seen = s_q.seen || o_valid;
            if (s_q.idx == LAST_LANE) begin
                s_d.have = 1'b0;
                if (s_q.last) begin
                    s_d.done  = 1'b1;
                    s_d.empty = !(s_q.seen || o_valid);
                    s_d.seen  = 1'b0;
                end
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done  = s_q.done;
    assign empty = s_q.empty;

    // R7: an idle value may only leave the block as the product of an escape
    a_r7_idle_only_escaped: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_byte == IDLE_CODE) |-> s_q.esc);

    a_r10_empty_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> done);

    a_r11_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_byte)));
endmodule

// File: rtl/bytelink_codec.sv
module bytelink_codec #(
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      tx_byte,
    input  logic            tx_valid,
    output logic            tx_ready,
    input  logic            tx_flush,
    output logic [NB*8-1:0] txw_data,
    output logic            txw_valid,
    input  logic            txw_ready,
    input  logic [NB*8-1:0] rxw_data,
    input  logic            rxw_last,
    input  logic            rxw_valid,
    output logic            rxw_ready,
    output logic [7:0]      rx_byte,
    output logic            rx_valid,
    input  logic            rx_ready,
    output logic            rx_done,
    output logic            rx_empty
);
    logic [7:0] esc_byte;
    logic       esc_valid;
    logic       esc_ready;

    bl_tx_escaper u_esc (
        .clk(clk), .rst_n(rst_n),
        .in_byte(tx_byte), .in_valid(tx_valid), .in_ready(tx_ready),
        .out_byte(esc_byte), .out_valid(esc_valid), .out_ready(esc_ready)
    );

    bl_tx_packer #(.NB(NB)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .in_byte(esc_byte), .in_valid(esc_valid), .in_ready(esc_ready),
        .flush(tx_flush),
        .w_data(txw_data), .w_valid(txw_valid), .w_ready(txw_ready)
    );

    bl_rx_unpacker #(.NB(NB)) u_unpack (
        .clk(clk), .rst_n(rst_n),
        .w_data(rxw_data), .w_last(rxw_last), .w_valid(rxw_valid), .w_ready(rxw_ready),
        .o_byte(rx_byte), .o_valid(rx_valid), .o_ready(rx_ready),
        .done(rx_done), .empty(rx_empty)
    );
endmodule

// File: tb/sim_bytelink_codec.sv
module sim_bytelink_codec;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tx_byte = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        tx_flush = 1'b0;
    logic [31:0] txw_data;
    logic        txw_valid;
    logic        txw_ready = 1'b0;
    logic [31:0] rxw_data = '0;
    logic        rxw_last = 1'b0;
    logic        rxw_valid = 1'b0;
    logic        rxw_ready;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic        rx_done;
    logic        rx_empty;

    int checks = 0;
    int failures = 0;
    logic [7:0] got[$];
    int done_cnt = 0;
    int empty_cnt = 0;

    always #(PERIOD/2) clk = ~clk;

    bytelink_codec u0 (.*);

    always @(posedge clk) begin
        if (rst_n) begin
            if (rx_valid && rx_ready) got.push_back(rx_byte);
            if (rx_done) done_cnt++;
            if (rx_empty) empty_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        tx_byte = b; tx_valid = 1'b1; #1;
        while (!tx_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic get_word(input logic fl, output logic [31:0] w);
        tx_flush = fl; txw_ready = 1'b1; #1;
        while (!txw_valid) begin @(negedge clk); #1; end
        w = txw_data;
        @(posedge clk); @(negedge clk);
        txw_ready = 1'b0; tx_flush = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w, input logic last);
        rxw_data = w; rxw_last = last; rxw_valid = 1'b1; #1;
        while (!rxw_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        rxw_valid = 1'b0; rxw_last = 1'b0;
    endtask

    task automatic rx_clear();
        got.delete(); done_cnt = 0; empty_cnt = 0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 txw_valid", {31'd0, txw_valid}, 32'd0);
        check("R1 tx_ready", {31'd0, tx_ready}, 32'd1);
        check("R1 rxw_ready", {31'd0, rxw_ready}, 32'd1);
        check("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
        check("R1 rx_done/empty", {30'd0, rx_done, rx_empty}, 32'd0);
    endtask

    task automatic t_plain_word();
        logic [31:0] w;
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
        #1;
        check("R4 word offered when full", {31'd0, txw_valid}, 32'd1);
        check("R4 tx_ready low while full", {31'd0, tx_ready}, 32'd0);
        get_word(1'b0, w);
        check("R2 big-endian lanes", w, 32'h11223344);
    endtask

    task automatic t_escape_tx();
        logic [31:0] w;
        send_byte(8'h4A); send_byte(8'h01); cycles(2);
        get_word(1'b1, w);
        check("R3 idle escaped, R4 pad", w, 32'h4D6A014A);
        send_byte(8'h4D); cycles(2);
        get_word(1'b1, w);
        check("R3 escape escaped", w, 32'h4D6D4A4A);
    endtask

    task automatic t_idle_flush();
        logic [31:0] w;
        get_word(1'b1, w);
        check("R5 idle word", w, 32'h4A4A4A4A);
    endtask

    task automatic t_rx_plain();
        rx_clear();
        send_word(32'h41424344, 1'b1); cycles(8);
        check("R6 byte count", got.size(), 32'd4);
        if (got.size() == 4) check("R6 order", {got[0], got[1], got[2], got[3]}, 32'h41424344);
        check("R10 done pulse", done_cnt, 32'd1);
        check("R10 not empty", empty_cnt, 32'd0);
    endtask

    task automatic t_rx_all_idle();
        rx_clear();
        send_word(32'h4A4A4A4A, 1'b1); cycles(8);
        check("R7 idle dropped", got.size(), 32'd0);
        check("R10 done on empty", done_cnt, 32'd1);
        check("R10 empty flag", empty_cnt, 32'd1);
    endtask

    task automatic t_rx_escape();
        rx_clear();
        send_word(32'h4A4D6A4A, 1'b1); cycles(8);
        check("R8 escaped idle count", got.size(), 32'd1);
        if (got.size() == 1) check("R8 escaped idle value", {24'd0, got[0]}, 32'h4A);
        rx_clear();
        send_word(32'h014D6D02, 1'b1); cycles(8);
        check("R8 escaped esc count", got.size(), 32'd3);
        if (got.size() == 3) check("R8 escaped esc values", {8'd0, got[0], got[1], got[2]}, 32'h00014D02);
    endtask

    task automatic t_rx_split();
        rx_clear();
        send_word(32'h1122334D, 1'b0);
        send_word(32'h6A4A4A4A, 1'b1); cycles(10);
        check("R9 split count", got.size(), 32'd4);
        if (got.size() == 4) check("R9 split values", {got[0], got[1], got[2], got[3]}, 32'h1122334A);
        check("R10 one done over two words", done_cnt, 32'd1);
        check("R10 split not empty", empty_cnt, 32'd0);
    endtask

    task automatic t_stall();
        logic [31:0] w;
        logic [31:0] snap;
        rx_clear();
        rx_ready = 1'b0;
        send_word(32'h55667788, 1'b1); cycles(1); #1;
        check("R11 rx valid under stall", {31'd0, rx_valid}, 32'd1);
        check("R11 rx byte first", {24'd0, rx_byte}, 32'h55);
        cycles(3); #1;
        check("R11 rx byte held", {23'd0, rx_valid, rx_byte}, 32'h155);
        rx_ready = 1'b1; cycles(8);
        check("R11 rx after release", got.size(), 32'd4);
        send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC); send_byte(8'hDD);
        #1; snap = txw_data;
        cycles(3); #1;
        check("R11 tx word held", txw_data, snap);
        check("R11 tx valid held", {31'd0, txw_valid}, 32'd1);
        get_word(1'b0, w);
        check("R11 tx word value", w, 32'hAABBCCDD);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_word();
        t_escape_tx();
        t_idle_flush();
        t_rx_plain();
        t_rx_all_idle();
        t_rx_escape();
        t_rx_split();
        t_stall();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule